// File: doc/BRIEF.md
# Sequential Integer Divider with Zero-Divisor Trap

This block divides two 32-bit integers over several clock cycles. A one-cycle `start` pulse captures the dividend, the divisor and a mode bit. The mode bit picks two's-complement or unsigned division. For a nonzero divisor the block runs a restoring shift-subtract loop on the operand magnitudes, one quotient bit per cycle. It then negates the result when the signs call for it. The quotient is truncated toward zero.

A zero divisor takes a short path. The quotient becomes 0 and a sticky divide-by-zero status flag is set. Both appear together with `done` one cycle after `start`. A trap request is raised only when the exception-enable input is high and the configuration mask bit is low. In that case a 5-bit cause register is loaded with the divide-by-zero code.

The surrounding pipeline stalls on its own until `done` and handles trap vectoring itself. No remainder is produced.

Top module: `trapping_divider`

## Requirements
- R1: With a nonzero divisor in unsigned mode (`is_signed`=0), `quotient` becomes floor(dividend/divisor), and `done` is high for exactly one cycle. Both appear 32 clock edges after the edge that accepted `start`. `quotient` changes at no other time.
- R2: In signed mode (`is_signed`=1), both operands are two's-complement values and the quotient is truncated toward zero. Examples: -7/2 gives -3, and 7/-2 gives -3.
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives 0x80000000. It does not set the divide-by-zero flag and raises no trap.
- R4: With a zero divisor, `quotient` becomes 0 and `done` pulses on the edge right after the accepting edge.
- R5: `dz_flag` is set by an accepted division with a zero divisor. It is cleared by an accepted division with a nonzero divisor. Otherwise it holds its value.
- R6: `exc_req` pulses for one cycle, together with `done`, only for a zero divisor while `exc_enable`=1 and `dz_exc_mask`=0. In every other case it stays 0.
- R7: `exc_cause` loads the value 5 whenever `exc_req` is raised, and otherwise holds its value.
- R8: A `start` that arrives while a division is running is ignored. It changes no output and does not shorten or restart the running division.
- R9: After reset, `quotient`, `done`, `dz_flag`, `exc_req` and `exc_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (ignored while busy) |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| is_signed | input | 1 | 1 = two's-complement division, 0 = unsigned |
| exc_enable | input | 1 | Global exception enable |
| dz_exc_mask | input | 1 | Configuration bit; 1 suppresses the divide-by-zero trap |
| quotient | output | 32 | Result of the last completed division |
| done | output | 1 | One-cycle completion pulse |
| dz_flag | output | 1 | Sticky divide-by-zero status |
| exc_req | output | 1 | One-cycle trap request |
| exc_cause | output | 5 | Trap cause register (5 = divide by zero) |

## Verification
The assertions assume that `start` is meaningful only when the engine is idle. The top gates it internally, so a request raised while busy never reaches the engine as a load. The assertions also assume that operands and control bits are sampled only on the accepting edge.

The stimulus holds inputs steady across each clock edge and drops `start` after one cycle. It deliberately pulses `start` in the middle of a division to exercise the gating. It also sweeps every combination of enable and mask for zero divisors.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    localparam int CAUSE_W = 5;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_DIV_ZERO = cause_t'(5);

    typedef struct packed {
        logic dz;     // divisor was zero
        logic raise;  // trap must be requested
    } fault_t;

    function automatic fault_t judge_fault(input logic b_zero,
                                           input logic exc_en,
                                           input logic mask);
        fault_t f;
        f.dz    = b_zero;
        f.raise = b_zero && exc_en && !mask;
        return f;
    endfunction

endpackage

// File: rtl/tdiv_operand.sv
module tdiv_operand #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sgn,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_q,
    output logic         b_zero
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg  = sgn && op_a[W-1];
        b_neg  = sgn && op_b[W-1];
        mag_a  = a_neg ? (~op_a + 1'b1) : op_a;
        mag_b  = b_neg ? (~op_b + 1'b1) : op_b;
        neg_q  = a_neg ^ b_neg;
        b_zero = (op_b == '0);
    end
endmodule

// File: rtl/tdiv_engine.sv
module tdiv_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         zero,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    input  logic         neg_q,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, acc_q, dvs_q;
    logic          neg_r;
    logic [CW-1:0] cnt_q;

    logic [W:0]   shifted, diff;
    logic         fits;
    logic [W-1:0] rem_nx, acc_nx, signed_res;

    always_comb begin
        shifted    = {rem_q, acc_q[W-1]};
        fits       = shifted >= {1'b0, dvs_q};
        diff       = shifted - {1'b0, dvs_q};
        rem_nx     = fits ? diff[W-1:0] : shifted[W-1:0];
        acc_nx     = {acc_q[W-2:0], fits};
        signed_res = neg_r ? (~acc_nx + 1'b1) : acc_nx;
    end

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            acc_q <= '0;
            dvs_q <= '0;
            neg_r <= 1'b0;
            cnt_q <= '0;
            fin   <= 1'b0;
            quot  <= '0;
        end else begin
            fin <= 1'b0;
            if (busy) begin
                rem_q <= rem_nx;
                acc_q <= acc_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    fin  <= 1'b1;
                    quot <= signed_res;
                end
            end else if (load) begin
                if (zero) begin
                    quot <= '0;
                    fin  <= 1'b1;
                end else begin
                    rem_q <= '0;
                    acc_q <= mag_a;
                    dvs_q <= mag_b;
                    neg_r <= neg_q;
                    cnt_q <= CW'(W);
                end
            end
        end
    end

    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
        (load && zero && !busy) |=> (fin && quot == '0)); // R4
    AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fin |-> $stable(quot)); // R1
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy); // R8
endmodule

// File: rtl/tdiv_fault.sv
module tdiv_fault
    import tdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   b_zero,
    input  logic   exc_en,
    input  logic   mask,
    output logic   dz_flag,
    output logic   exc_req,
    output cause_t exc_cause
);
    fault_t verdict;

    always_comb verdict = judge_fault(b_zero, exc_en, mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            dz_flag   <= 1'b0;
            exc_req   <= 1'b0;
            exc_cause <= '0;
        end else begin
            exc_req <= 1'b0;
            if (accept) begin
                dz_flag <= verdict.dz;
                if (verdict.raise) begin
                    exc_req   <= 1'b1;
                    exc_cause <= CAUSE_DIV_ZERO;
                end
            end
        end
    end

    AST_EXC_NEEDS_DZ: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> dz_flag); // R6
    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (exc_cause == CAUSE_DIV_ZERO)); // R7
    AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (accept && !b_zero) |=> (!dz_flag && !exc_req)); // R5
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> $stable(exc_cause)); // R7
endmodule

// File: rtl/trapping_divider.sv
module trapping_divider
    import tdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [W-1:0]       dividend,
    input  logic [W-1:0]       divisor,
    input  logic               is_signed,
    input  logic               exc_enable,
    input  logic               dz_exc_mask,
    output logic [W-1:0]       quotient,
    output logic               done,
    output logic               dz_flag,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);
    logic [W-1:0] mag_a, mag_b;
    logic         neg_q, b_zero, busy, accept;
    cause_t       cause_w;

    assign accept    = start && !busy;
    assign exc_cause = cause_w;

    tdiv_operand #(.W(W)) u_operand (
        .op_a   (dividend),
        .op_b   (divisor),
        .sgn    (is_signed),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .neg_q  (neg_q),
        .b_zero (b_zero)
    );

    tdiv_engine #(.W(W)) u_engine (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .zero  (b_zero),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .neg_q (neg_q),
        .busy  (busy),
        .fin   (done),
        .quot  (quotient)
    );

    tdiv_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .b_zero    (b_zero),
        .exc_en    (exc_enable),
        .mask      (dz_exc_mask),
        .dz_flag   (dz_flag),
        .exc_req   (exc_req),
        .exc_cause (cause_w)
    );

    AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> done); // R6
endmodule

// File: tb/trapping_divider_test.sv
module trapping_divider_test;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  dividend = '0, divisor = '0;
    logic          is_signed = 1'b0, exc_enable = 1'b0, dz_exc_mask = 1'b0;
    logic [W-1:0]  quotient;
    logic          done, dz_flag, exc_req;
    logic [4:0]    exc_cause;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string tag = "R9";

    // behavioural reference state
    logic [W-1:0] m_q, m_pend;
    logic         m_done, m_dz, m_exc;
    logic [4:0]   m_cause;
    int           m_cnt;

    always #5 clk = ~clk;

    trapping_divider #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .is_signed(is_signed), .exc_enable(exc_enable),
        .dz_exc_mask(dz_exc_mask), .quotient(quotient), .done(done),
        .dz_flag(dz_flag), .exc_req(exc_req), .exc_cause(exc_cause)
    );

    function automatic logic [W-1:0] ref_div(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic s);
        longint la, lb, lq;
        if (s) begin
            la = longint'($signed(a));
            lb = longint'($signed(b));
        end else begin
            la = longint'({32'd0, a});
            lb = longint'({32'd0, b});
        end
        lq = la / lb;
        return lq[W-1:0];
    endfunction

    always @(posedge clk) begin
        m_done <= 1'b0;
        m_exc  <= 1'b0;
        if (rst) begin
            m_q <= '0; m_pend <= '0; m_dz <= 1'b0; m_cause <= '0; m_cnt <= 0;
        end else if (m_cnt > 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                m_done <= 1'b1;
                m_q    <= m_pend;
            end
        end else if (start) begin
            if (divisor == '0) begin
                m_q    <= '0;
                m_done <= 1'b1;
                m_dz   <= 1'b1;
                if (exc_enable && !dz_exc_mask) begin
                    m_exc   <= 1'b1;
                    m_cause <= 5'd5;
                end
            end else begin
                m_dz   <= 1'b0;
                m_cnt  <= W;
                m_pend <= ref_div(dividend, divisor, is_signed);
            end
        end
    end

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("quotient", longint'(quotient), longint'(m_q));
            check("done", longint'(done), longint'(m_done));
            check("dz_flag", longint'(dz_flag), longint'(m_dz));
            check("exc_req", longint'(exc_req), longint'(m_exc));
            check("exc_cause", longint'(exc_cause), longint'(m_cause));
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_op(input string t, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic s, input logic en, input logic msk);
        @(negedge clk);
        tag = t;
        dividend = a; divisor = b; is_signed = s; exc_enable = en; dz_exc_mask = msk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R9";
        check("quotient", longint'(quotient), 0);
        check("done", longint'(done), 0);
        check("dz_flag", longint'(dz_flag), 0);
        check("exc_req", longint'(exc_req), 0);
        check("exc_cause", longint'(exc_cause), 0);
        rst = 1'b0;

        run_op("R1", 32'd100, 32'd7, 1'b0, 1'b0, 1'b0);
        run_op("R1", 32'hFFFFFFFF, 32'd3, 1'b0, 1'b1, 1'b0);
        run_op("R1", 32'd5, 32'd9, 1'b0, 1'b0, 1'b0);
        run_op("R2", 32'hFFFFFFF9, 32'd2, 1'b1, 1'b0, 1'b0);
        run_op("R2", 32'd7, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0);
        run_op("R2", 32'hFFFFFF9C, 32'hFFFFFFF6, 1'b1, 1'b0, 1'b0);
        run_op("R2", 32'hFFFFFFF9, 32'd2, 1'b0, 1'b0, 1'b0);
        run_op("R4", 32'd1234, 32'd0, 1'b0, 1'b0, 1'b0);
        run_op("R5", 32'd10, 32'd2, 1'b1, 1'b0, 1'b0);
        run_op("R6", 32'd9, 32'd0, 1'b1, 1'b1, 1'b0);
        run_op("R6", 32'd9, 32'd0, 1'b1, 1'b1, 1'b1);
        run_op("R7", 32'd9, 32'd0, 1'b0, 1'b0, 1'b1);
        run_op("R3", 32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0);
        tag = "R3";
        check("quotient", longint'(quotient), longint'(32'h80000000));
        check("dz_flag", longint'(dz_flag), 0);

        // R8: start with zero divisor arrives mid-division
        @(negedge clk);
        tag = "R8";
        dividend = 32'd1000; divisor = 32'd10; is_signed = 1'b0;
        exc_enable = 1'b1; dz_exc_mask = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        divisor = 32'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("done", longint'(done), 0);
        check("exc_req", longint'(exc_req), 0);
        check("dz_flag", longint'(dz_flag), 0);
        repeat (W) @(negedge clk);
        check("quotient", longint'(quotient), 100);

        run_op("R4", 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule